// File: doc/BRIEF.md
# Hop-Relative Deadline Header Rewriter

This block sits on a switch or host port. It lets packet deadlines cross nodes whose clocks are not synchronised. Inside a node, a packet is scheduled by an absolute deadline expressed in that node's local time. On the wire, the header instead carries the time still remaining to the destination.

The egress direction accepts a local deadline together with the other header bits. When the packet is accepted, it subtracts the local time and clamps the result into a 16-bit field. It then writes a fresh CRC-16 over the header, because that field changes at every hop. The ingress direction accepts a received header and checks its CRC. It rebuilds a local absolute deadline by adding the receiving node's local time at acceptance, and that deadline is then used for local scheduling.

Each direction is a one-entry pipeline stage with two named states. In `ST_EMPTY` the stage is ready and holds nothing. The transition `EMPTY->FULL` happens on an accepted input. In `ST_FULL` the result is presented downstream. The transition `FULL->EMPTY` happens when the result is taken and nothing new enters. The `FULL->FULL` path is taken on a stall, or when a new input is accepted in the same cycle as the output leaves.

Top module: `ttd_header_rewriter`

## Requirements
- R1: On egress, when the wrap-aware difference (deadline minus local time, taken modulo 2^32) lies between 0 and 65535, header bits [63:48] equal that difference. The local time used is the value in the cycle the input is accepted.
- R2: On egress, when that 32-bit difference has its top bit set (the deadline has passed), bits [63:48] are 0.
- R3: On egress, when the difference is positive and above 65535, bits [63:48] are 0xFFFF.
- R4: The egress header carries the input's other fields unchanged in bits [47:16]. Bits [15:0] hold a CRC-16 over bits [63:16], processed from bit 63 downward, with polynomial 0x1021, initial value 0xFFFF, no reflection and no final inversion.
- R5: On ingress, the output deadline equals bits [63:48] plus the local time in the cycle of acceptance, modulo 2^32. Bits [47:16] appear unchanged on the other-fields output.
- R6: On ingress, a header whose bits [15:0] differ from the CRC of R4 over its bits [63:16] raises the error output, and its output deadline is 0. A matching header gives error 0.
- R7: A header accepted in cycle n is presented with valid high in cycle n+1.
- R8: An input is ready exactly when its stage's output is not valid or is being taken. An output that is valid and not taken stays valid and unchanged in the next cycle. One header per cycle flows through each direction.
- R9: After reset, neither output is valid and both inputs are ready.
- R10: The two directions are independent. Headers accepted in both directions in the same cycle both use that cycle's local time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| local_time | input | 32 | Free-running local clock value |
| tx_in_valid | input | 1 | Egress request valid |
| tx_in_ready | output | 1 | Egress stage can accept |
| tx_in_deadline | input | 32 | Local absolute deadline of departing packet |
| tx_in_other | input | 32 | Routing and other header bits |
| tx_out_valid | output | 1 | Rewritten header valid |
| tx_out_ready | input | 1 | Downstream takes rewritten header |
| tx_out_hdr | output | 64 | Header with remaining-time field and CRC |
| rx_in_valid | input | 1 | Received header valid |
| rx_in_ready | output | 1 | Ingress stage can accept |
| rx_in_hdr | input | 64 | Received header |
| rx_out_valid | output | 1 | Rebuilt result valid |
| rx_out_ready | input | 1 | Scheduler takes rebuilt result |
| rx_out_deadline | output | 32 | Rebuilt local absolute deadline (0 on CRC error) |
| rx_out_other | output | 32 | Routing and other header bits |
| rx_out_crc_err | output | 1 | Received header failed its CRC check |

## Verification
The egress rewrite and the ingress rebuild can both be accepted in the same clock edge. They share only the local time value. The bench provokes this with a directed cycle where both inputs are valid and both outputs are ready at a chosen time, followed by a long stretch of random valid and ready patterns where such overlaps are frequent. Each overlap is judged by checking that both results reflect the identical local time and that neither direction's stall pattern disturbs the other's output.

// File: rtl/ttd_pkg.sv
package ttd_pkg;
    typedef enum logic {
        ST_EMPTY = 1'b0,
        ST_FULL  = 1'b1
    } stage_state_e;
endpackage

// File: rtl/ttd_crc.sv
module ttd_crc #(
    parameter int          DATA_W = 48,
    parameter int          CRC_W  = 16,
    parameter logic [15:0] POLY   = 16'h1021,
    parameter logic [15:0] INIT   = 16'hFFFF
) (
    input  logic [DATA_W-1:0] data,
    output logic [CRC_W-1:0]  crc
);
    // Bit-serial CRC, unrolled: MSB of data enters first.
    always_comb begin
        logic [CRC_W-1:0] acc;
        logic             fb;
        acc = INIT[CRC_W-1:0];
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb  = acc[CRC_W-1] ^ data[i];
            acc = {acc[CRC_W-2:0], 1'b0};
            if (fb) begin
                acc = acc ^ POLY[CRC_W-1:0];
            end
        end
        crc = acc;
    end
endmodule

// File: rtl/ttd_egress_stage.sv
module ttd_egress_stage
    import ttd_pkg::*;
#(
    parameter int TIME_W  = 32,
    parameter int FIELD_W = 16,
    parameter int OTHER_W = 32,
    parameter int CRC_W   = 16,
    localparam int HDR_W  = FIELD_W + OTHER_W + CRC_W,
    localparam int COV_W  = FIELD_W + OTHER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  now,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [TIME_W-1:0]  in_deadline,
    input  logic [OTHER_W-1:0] in_other,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [HDR_W-1:0]   out_hdr
);
    localparam logic [TIME_W-1:0] FIELD_MAX = TIME_W'((64'd1 << FIELD_W) - 64'd1);

    stage_state_e state_q, state_d;
    logic [FIELD_W-1:0] field_q, field_d;
    logic [OTHER_W-1:0] other_q;
    logic [TIME_W-1:0]  remain;
    logic [CRC_W-1:0]   crc;
    logic               accept;

    // Remaining time, clamped into the header field.
    always_comb begin
        remain = in_deadline - now;
        if (remain[TIME_W-1]) begin
            field_d = '0;
        end else if (remain > FIELD_MAX) begin
            field_d = '1;
        end else begin
            field_d = remain[FIELD_W-1:0];
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    // Output logic.
    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            field_q <= '0;
            other_q <= '0;
        end else if (accept) begin
            field_q <= field_d;
            other_q <= in_other;
        end
    end

    ttd_crc #(.DATA_W(COV_W), .CRC_W(CRC_W)) u_crc (
        .data ({field_q, other_q}),
        .crc  (crc)
    );

    assign out_hdr = {field_q, other_q, crc};
endmodule

// File: rtl/ttd_ingress_stage.sv
module ttd_ingress_stage
    import ttd_pkg::*;
#(
    parameter int TIME_W  = 32,
    parameter int FIELD_W = 16,
    parameter int OTHER_W = 32,
    parameter int CRC_W   = 16,
    localparam int HDR_W  = FIELD_W + OTHER_W + CRC_W,
    localparam int COV_W  = FIELD_W + OTHER_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  now,
    input  logic               in_valid,
    output logic               in_ready,
    input  logic [HDR_W-1:0]   in_hdr,
    output logic               out_valid,
    input  logic               out_ready,
    output logic [TIME_W-1:0]  out_deadline,
    output logic [OTHER_W-1:0] out_other,
    output logic               out_crc_err
);
    stage_state_e state_q, state_d;
    logic [CRC_W-1:0]   crc_calc;
    logic               bad_d;
    logic [TIME_W-1:0]  deadline_d;
    logic [TIME_W-1:0]  deadline_q;
    logic [OTHER_W-1:0] other_q;
    logic               bad_q;
    logic               accept;

    ttd_crc #(.DATA_W(COV_W), .CRC_W(CRC_W)) u_crc (
        .data (in_hdr[HDR_W-1:CRC_W]),
        .crc  (crc_calc)
    );

    // Rebuild the local deadline; suppress it when the header is corrupt.
    always_comb begin
        bad_d = (crc_calc != in_hdr[CRC_W-1:0]);
        if (bad_d) begin
            deadline_d = '0;
        end else begin
            deadline_d = now + TIME_W'(in_hdr[HDR_W-1:COV_W]);
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_EMPTY: if (in_valid) state_d = ST_FULL;
            ST_FULL:  if (out_ready && !in_valid) state_d = ST_EMPTY;
            default:  state_d = ST_EMPTY;
        endcase
    end

    always_comb begin
        in_ready  = 1'b1;
        out_valid = 1'b0;
        unique case (state_q)
            ST_EMPTY: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
            ST_FULL: begin
                in_ready  = out_ready;
                out_valid = 1'b1;
            end
            default: begin
                in_ready  = 1'b1;
                out_valid = 1'b0;
            end
        endcase
    end

    assign accept = in_valid && in_ready;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_EMPTY;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            deadline_q <= '0;
            other_q    <= '0;
            bad_q      <= 1'b0;
        end else if (accept) begin
            deadline_q <= deadline_d;
            other_q    <= in_hdr[COV_W-1:CRC_W];
            bad_q      <= bad_d;
        end
    end

    assign out_deadline = deadline_q;
    assign out_other    = other_q;
    assign out_crc_err  = bad_q;
endmodule

// File: rtl/ttd_header_rewriter.sv
module ttd_header_rewriter #(
    parameter int TIME_W  = 32,
    parameter int FIELD_W = 16,
    parameter int OTHER_W = 32,
    parameter int CRC_W   = 16,
    localparam int HDR_W  = FIELD_W + OTHER_W + CRC_W
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [TIME_W-1:0]  local_time,
    input  logic               tx_in_valid,
    output logic               tx_in_ready,
    input  logic [TIME_W-1:0]  tx_in_deadline,
    input  logic [OTHER_W-1:0] tx_in_other,
    output logic               tx_out_valid,
    input  logic               tx_out_ready,
    output logic [HDR_W-1:0]   tx_out_hdr,
    input  logic               rx_in_valid,
    output logic               rx_in_ready,
    input  logic [HDR_W-1:0]   rx_in_hdr,
    output logic               rx_out_valid,
    input  logic               rx_out_ready,
    output logic [TIME_W-1:0]  rx_out_deadline,
    output logic [OTHER_W-1:0] rx_out_other,
    output logic               rx_out_crc_err
);
    ttd_egress_stage #(
        .TIME_W(TIME_W), .FIELD_W(FIELD_W), .OTHER_W(OTHER_W), .CRC_W(CRC_W)
    ) u_tx (
        .clk         (clk),
        .rst_n       (rst_n),
        .now         (local_time),
        .in_valid    (tx_in_valid),
        .in_ready    (tx_in_ready),
        .in_deadline (tx_in_deadline),
        .in_other    (tx_in_other),
        .out_valid   (tx_out_valid),
        .out_ready   (tx_out_ready),
        .out_hdr     (tx_out_hdr)
    );

    ttd_ingress_stage #(
        .TIME_W(TIME_W), .FIELD_W(FIELD_W), .OTHER_W(OTHER_W), .CRC_W(CRC_W)
    ) u_rx (
        .clk          (clk),
        .rst_n        (rst_n),
        .now          (local_time),
        .in_valid     (rx_in_valid),
        .in_ready     (rx_in_ready),
        .in_hdr       (rx_in_hdr),
        .out_valid    (rx_out_valid),
        .out_ready    (rx_out_ready),
        .out_deadline (rx_out_deadline),
        .out_other    (rx_out_other),
        .out_crc_err  (rx_out_crc_err)
    );
endmodule

// File: rtl/ttd_header_rewriter_chk.sv
module ttd_header_rewriter_chk #(
    parameter int TIME_W  = 32,
    parameter int FIELD_W = 16,
    parameter int OTHER_W = 32,
    parameter int CRC_W   = 16,
    localparam int HDR_W  = FIELD_W + OTHER_W + CRC_W
) (
    input logic               clk,
    input logic               rst_n,
    input logic               tx_in_valid,
    input logic               tx_in_ready,
    input logic               tx_out_valid,
    input logic               tx_out_ready,
    input logic [HDR_W-1:0]   tx_out_hdr,
    input logic               rx_in_valid,
    input logic               rx_in_ready,
    input logic               rx_out_valid,
    input logic               rx_out_ready,
    input logic [TIME_W-1:0]  rx_out_deadline,
    input logic               rx_out_crc_err
);
    p_tx_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_in_valid && tx_in_ready |=> tx_out_valid);

    p_rx_latency_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_in_valid && rx_in_ready |=> rx_out_valid);

    p_tx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid && !tx_out_ready |=> tx_out_valid && $stable(tx_out_hdr));

    p_rx_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid && !rx_out_ready |=> rx_out_valid && $stable(rx_out_deadline));

    p_tx_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_out_valid |-> tx_in_ready);

    p_rx_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rx_out_valid |-> rx_in_ready);

    p_rx_err_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_out_valid && rx_out_crc_err |-> rx_out_deadline == '0);

    p_tx_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_valid && tx_out_ready && !tx_in_valid |=> !tx_out_valid);
endmodule

bind ttd_header_rewriter ttd_header_rewriter_chk #(
    .TIME_W(TIME_W), .FIELD_W(FIELD_W), .OTHER_W(OTHER_W), .CRC_W(CRC_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .tx_in_valid     (tx_in_valid),
    .tx_in_ready     (tx_in_ready),
    .tx_out_valid    (tx_out_valid),
    .tx_out_ready    (tx_out_ready),
    .tx_out_hdr      (tx_out_hdr),
    .rx_in_valid     (rx_in_valid),
    .rx_in_ready     (rx_in_ready),
    .rx_out_valid    (rx_out_valid),
    .rx_out_ready    (rx_out_ready),
    .rx_out_deadline (rx_out_deadline),
    .rx_out_crc_err  (rx_out_crc_err)
);

// File: tb/ttd_header_rewriter_test.sv
module ttd_header_rewriter_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic [31:0] local_time;
    logic        tx_in_valid, tx_in_ready, tx_out_valid, tx_out_ready;
    logic [31:0] tx_in_deadline, tx_in_other;
    logic [63:0] tx_out_hdr;
    logic        rx_in_valid, rx_in_ready, rx_out_valid, rx_out_ready;
    logic [63:0] rx_in_hdr;
    logic [31:0] rx_out_deadline, rx_out_other;
    logic        rx_out_crc_err;

    always #5 clk = ~clk;

    ttd_header_rewriter uut (.*);

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [63:0] tx_q[$];
    string       tx_tag_q[$];
    logic [64:0] rx_q[$];   // {err, deadline, other}

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [47:0] d);
        logic [16:0] r;
        r = 17'h0FFFF;
        for (int k = 47; k >= 0; k--) begin
            r = {r[15:0], 1'b0} ^ (r[15] != d[k] ? 17'h11021 : 17'h0);
            r[16] = 1'b0;
        end
        return r[15:0];
    endfunction

    function automatic logic [63:0] good_hdr(input logic [15:0] f, input logic [31:0] o);
        return {f, o, ref_crc({f, o})};
    endfunction

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    // Evaluate one cycle: inputs already set after a falling edge.
    task automatic step();
        int signed   diff;
        logic [15:0] f;
        string       tg;
        logic [63:0] e;
        logic [64:0] r;
        logic        bad;
        #1;
        chk(tx_out_valid == (tx_q.size() != 0), "R7 tx valid", 64'(tx_out_valid), 64'(tx_q.size() != 0));
        chk(rx_out_valid == (rx_q.size() != 0), "R7 rx valid", 64'(rx_out_valid), 64'(rx_q.size() != 0));
        chk(tx_in_ready == (!tx_out_valid || tx_out_ready), "R8 tx ready", 64'(tx_in_ready), 64'(!tx_out_valid || tx_out_ready));
        chk(rx_in_ready == (!rx_out_valid || rx_out_ready), "R8 rx ready", 64'(rx_in_ready), 64'(!rx_out_valid || rx_out_ready));
        if (tx_out_valid && tx_out_ready && tx_q.size() != 0) begin
            e  = tx_q.pop_front();
            tg = tx_tag_q.pop_front();
            chk(tx_out_hdr[63:48] == e[63:48], tg, 64'(tx_out_hdr[63:48]), 64'(e[63:48]));
            chk(tx_out_hdr[47:0] == e[47:0], "R4 other/crc", 64'(tx_out_hdr[47:0]), 64'(e[47:0]));
        end
        if (rx_out_valid && rx_out_ready && rx_q.size() != 0) begin
            r = rx_q.pop_front();
            chk(rx_out_crc_err == r[64], "R6 crc flag", 64'(rx_out_crc_err), 64'(r[64]));
            chk(rx_out_deadline == r[63:32], r[64] ? "R6 deadline zero" : "R5 deadline",
                64'(rx_out_deadline), 64'(r[63:32]));
            chk(rx_out_other == r[31:0], "R5 other", 64'(rx_out_other), 64'(r[31:0]));
        end
        if (tx_in_valid && tx_in_ready) begin
            diff = int'(tx_in_deadline - local_time);
            if (diff < 0) begin
                f = 16'h0; tg = "R2 passed deadline";
            end else if (diff > 65535) begin
                f = 16'hFFFF; tg = "R3 saturation";
            end else begin
                f = diff[15:0]; tg = "R1 remaining time";
            end
            tx_q.push_back(good_hdr(f, tx_in_other));
            tx_tag_q.push_back(tg);
        end
        if (rx_in_valid && rx_in_ready) begin
            bad = ref_crc(rx_in_hdr[63:16]) != rx_in_hdr[15:0];
            rx_q.push_back({bad, bad ? 32'h0 : local_time + {16'h0, rx_in_hdr[63:48]}, rx_in_hdr[47:16]});
        end
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic tx_drive(input logic [31:0] dl, input logic [31:0] o);
        tx_in_valid = 1'b1; tx_in_deadline = dl; tx_in_other = o;
    endtask

    initial begin
        rst_n = 1'b0; local_time = 32'd0;
        tx_in_valid = 0; tx_in_deadline = 0; tx_in_other = 0; tx_out_ready = 0;
        rx_in_valid = 0; rx_in_hdr = 0; rx_out_ready = 0;
        repeat (3) @(negedge clk);
        #1;
        // R9 reset state
        chk(!tx_out_valid && !rx_out_valid, "R9 outputs idle", 64'({tx_out_valid, rx_out_valid}), 64'd0);
        chk(tx_in_ready && rx_in_ready, "R9 inputs ready", 64'({tx_in_ready, rx_in_ready}), 64'd3);
        @(negedge clk);
        rst_n = 1'b1;
        tx_out_ready = 1; rx_out_ready = 1;

        // R10: both directions in one cycle with the same local time
        local_time = 32'd1000;
        tx_drive(32'd1500, 32'hA5A5_0001);
        rx_in_valid = 1; rx_in_hdr = good_hdr(16'd200, 32'h1234_5678);
        step();
        tx_in_valid = 0; rx_in_valid = 0; local_time = 32'd1001;
        #1;
        chk(tx_out_hdr[63:48] == 16'd500, "R10 tx uses shared time", 64'(tx_out_hdr[63:48]), 64'd500);
        chk(rx_out_deadline == 32'd1200, "R10 rx uses shared time", 64'(rx_out_deadline), 64'd1200);
        step();

        // Boundaries for R1, R2, R3 and a wrap case
        local_time = 32'd5000;
        tx_drive(32'd5000, 32'h1); step();               // diff 0
        tx_drive(32'd5000 + 65535, 32'h2); step();       // diff 65535
        tx_drive(32'd5000 + 65536, 32'h3); step();       // diff 65536
        tx_drive(32'd4999, 32'h4); step();               // diff -1
        local_time = 32'hFFFF_FFF0;
        tx_drive(32'h0000_0010, 32'h5); step();          // wrap, diff 32
        tx_in_valid = 0;

        // R6: corrupted header, then R5 wrap on ingress
        rx_in_valid = 1; rx_in_hdr = good_hdr(16'd7, 32'hDEAD_BEEF) ^ 64'h1; step();
        rx_in_hdr = good_hdr(16'hFFFF, 32'h0BAD_F00D); step();
        rx_in_valid = 0; step();

        // Random traffic with stalls
        for (int n = 0; n < 4000; n++) begin
            local_time   = local_time + (($urandom_range(0, 15) == 0) ? 32'($urandom) : 32'($urandom_range(0, 3)));
            tx_out_ready = ($urandom_range(0, 3) != 0);
            rx_out_ready = ($urandom_range(0, 3) != 0);
            tx_in_valid  = ($urandom_range(0, 2) != 0);
            rx_in_valid  = ($urandom_range(0, 2) != 0);
            tx_in_deadline = local_time + 32'($urandom_range(0, 90000)) - 32'd10000;
            tx_in_other    = $urandom;
            rx_in_hdr      = good_hdr(16'($urandom), $urandom);
            if ($urandom_range(0, 3) == 0) rx_in_hdr = rx_in_hdr ^ (64'd1 << $urandom_range(0, 63));
            step();
        end
        tx_in_valid = 0; rx_in_valid = 0; tx_out_ready = 1; rx_out_ready = 1;
        repeat (3) step();
        chk(tx_q.size() == 0 && rx_q.size() == 0, "R7 drained", 64'(tx_q.size() + rx_q.size()), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule